// File: doc/BRIEF.md
# Page Translation Cache

This block keeps recently completed address translations for 4 KiB pages so that a requester does not wait for a table walk on every access. It is fully associative. Each line holds the virtual page number (address bits 31:12) as its tag, the physical page number (physical address bits 31:12) as data, and a readable and a writable permission bit. A lookup that hits is answered in the same cycle with the full physical address, which is the stored page number joined to the untranslated 12-bit page offset.

On a miss the cache raises a walk request that carries the missing page number and holds it until the walker returns fill data. The filled line is chosen round-robin over the lines. A fill whose tag is already present rewrites that line in place. Software keeps the cache coherent with the page tables in two ways. It can drop the line of a single page by presenting any address inside that page. It can clear every line at once. To clear a range, single-page invalidations are issued one after another, stepping 4 KiB each time.

The lookup request and the translated response form one valid/ready pair. The requester holds `lk_valid` and `lk_va` stable until `lk_ready` is seen. The response is combinational from the request, so `lk_ready` is high exactly when `rsp_valid` and `rsp_ready` are both high. A stalled consumer therefore stalls the request, and `rsp_pa` stays steady while the request is held. Fill and invalidation inputs are single-cycle strobes and are always accepted.

Top module: `xlat_cache`

## Requirements
- R1: After reset no line is valid, `walk_req` and `rsp_valid` are low, and the first lookup of any address misses.
- R2: A lookup that hits, while no walk is pending, raises `rsp_valid` in the same cycle with `rsp_pa` = {stored page number, `lk_va`[11:0]} and the stored readable/writable bits on `rsp_rd`/`rsp_wr`.
- R3: `lk_ready` is high only when `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low and the request is held, `rsp_valid` and `rsp_pa` stay unchanged.
- R4: A lookup that misses raises `walk_req` from the next cycle, with `walk_vpn` = `lk_va`[31:12]. Both hold until a cycle with `fill_valid`, and no response is given while `walk_req` is high.
- R5: An accepted fill with a new tag writes the line at a round-robin pointer that starts at line 0 and advances by one per such fill, wrapping after the last line. With 8 lines, the ninth new tag evicts the first.
- R6: A fill whose tag matches a valid line rewrites that line and does not advance the pointer, so no tag is ever held twice.
- R7: With `inv_one_valid` high, the line whose tag equals `inv_va`[31:12] is invalid from the next cycle, and all other lines are unchanged.
- R8: With `inv_all` high, every line is invalid from the next cycle.
- R9: A fill in the same cycle as `inv_all`, or as an `inv_one_valid` for the same page, is dropped. A fill alongside a single-page invalidation of a different page is written.
- R10: A lookup in the same cycle as an invalidation that covers its page gets no response and starts no walk in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation response valid (hit) |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_pa | output | 32 | Translated physical address |
| rsp_rd | output | 1 | Page is readable |
| rsp_wr | output | 1 | Page is writable |
| walk_req | output | 1 | Table walk needed, held until a fill |
| walk_vpn | output | 20 | Virtual page number to walk |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_vpn | input | 20 | Tag of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_rd | input | 1 | Readable permission of the fill |
| fill_wr | input | 1 | Writable permission of the fill |
| inv_one_valid | input | 1 | Invalidate the line of one page |
| inv_va | input | 32 | Any address inside the page to invalidate |
| inv_all | input | 1 | Invalidate every line |

## Verification
The collision that matters is between a fill and an invalidation of the same page. If the fill wins, the cache keeps a stale translation after the page tables have changed. The bench drives a fill and a matching single-page invalidation in one cycle, then looks up that page and expects a miss. It also pairs a fill with an invalidation of a different page and expects a hit, and the random phase lets fills, lookups and both invalidation kinds land together freely. A cycle-level model in the bench applies the same priority and judges every response, walk request and permission bit.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef enum logic {
    XC_IDLE = 1'b0,
    XC_WAIT = 1'b1
  } xc_state_e;

  typedef struct packed {
    logic wr;
    logic rd;
  } xc_perm_t;

endpackage

// File: rtl/xc_store.sv
module xc_store
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  output xc_perm_t           lk_perm,
  input  logic [VPN_W-1:0]   dup_vpn,
  output logic               dup_hit,
  output logic [IDX_W-1:0]   dup_idx,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  xc_perm_t           wr_perm,
  input  logic               inv_one,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               inv_all,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [PPN_W-1:0]   ppn_arr  [ENTRIES];
  xc_perm_t           perm_arr [ENTRIES];
  logic [ENTRIES-1:0] dup_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    logic             vld_q;
    logic [VPN_W-1:0] tag_q;
    logic [PPN_W-1:0] ppn_q;
    xc_perm_t         perm_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    // flush-all beats a write, a write beats a single-page drop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          vld_q <= 1'b0;
      else if (inv_all)                    vld_q <= 1'b0;
      else if (sel)                        vld_q <= 1'b1;
      else if (inv_one && tag_q == inv_vpn) vld_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        ppn_q  <= '0;
        perm_q <= '0;
      end else if (sel) begin
        tag_q  <= dup_vpn;
        ppn_q  <= wr_ppn;
        perm_q <= wr_perm;
      end
    end

    assign hit_vec[g]   = vld_q && (tag_q == lk_vpn);
    assign dup_vec[g]   = vld_q && (tag_q == dup_vpn);
    assign valid_vec[g] = vld_q;
    assign ppn_arr[g]   = ppn_q;
    assign perm_arr[g]  = perm_q;
  end

  assign lk_hit  = |hit_vec;
  assign dup_hit = |dup_vec;

  // tags are unique, so an OR over matching lines is a clean mux
  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_ppn  = lk_ppn | ppn_arr[i];
        lk_perm = xc_perm_t'(lk_perm | perm_arr[i]);
      end
      if (dup_vec[i]) dup_idx = dup_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] nxt;

  if (ENTRIES == (1 << IDX_W)) begin : g_pow2
    assign nxt = ptr + IDX_W'(1);
  end else begin : g_wrap
    assign nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= nxt;
  end

endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xlat_cache_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic             lk_block,
  input  logic             rsp_ready,
  input  logic             fill_valid,
  output logic             rsp_valid,
  output logic             lk_ready,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn
);

  xc_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= XC_IDLE;
      walk_vpn <= '0;
    end else begin
      case (st_q)
        XC_IDLE: if (lk_valid && !lk_hit && !lk_block) begin
          st_q     <= XC_WAIT;
          walk_vpn <= lk_vpn;
        end
        XC_WAIT: if (fill_valid) st_q <= XC_IDLE;
        default: st_q <= XC_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == XC_IDLE) && lk_valid && lk_hit && !lk_block;
  assign lk_ready  = rsp_valid && rsp_ready;
  assign walk_req  = (st_q == XC_WAIT);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_va,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_rd,
  output logic             rsp_wr,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             inv_one_valid,
  input  logic [VA_W-1:0]  inv_va,
  input  logic             inv_all
);

  logic [VPN_W-1:0]   lk_vpn, inv_vpn;
  logic [ENTRIES-1:0] hit_vec, valid_vec;
  logic               lk_hit, dup_hit, lk_block, fill_block, wr_en;
  logic [PPN_W-1:0]   lk_ppn;
  xc_perm_t           lk_perm, fill_perm;
  logic [IDX_W-1:0]   dup_idx, rr_ptr, wr_idx;

  assign lk_vpn  = lk_va[VA_W-1:PAGE_W];
  assign inv_vpn = inv_va[VA_W-1:PAGE_W];

  // an invalidation touching the same page wins over a fill or a lookup
  assign fill_block = inv_all || (inv_one_valid && inv_vpn == fill_vpn);
  assign lk_block   = inv_all || (inv_one_valid && inv_vpn == lk_vpn);
  assign wr_en      = fill_valid && !fill_block;
  assign wr_idx     = dup_hit ? dup_idx : rr_ptr;

  assign fill_perm.rd = fill_rd;
  assign fill_perm.wr = fill_wr;

  xc_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (lk_vpn),
    .hit_vec  (hit_vec),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_perm  (lk_perm),
    .dup_vpn  (fill_vpn),
    .dup_hit  (dup_hit),
    .dup_idx  (dup_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_ppn   (fill_ppn),
    .wr_perm  (fill_perm),
    .inv_one  (inv_one_valid),
    .inv_vpn  (inv_vpn),
    .inv_all  (inv_all),
    .valid_vec(valid_vec)
  );

  xc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(wr_en && !dup_hit),
    .ptr    (rr_ptr)
  );

  xc_ctrl #(.VPN_W(VPN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .lk_hit    (lk_hit),
    .lk_block  (lk_block),
    .rsp_ready (rsp_ready),
    .fill_valid(fill_valid),
    .rsp_valid (rsp_valid),
    .lk_ready  (lk_ready),
    .walk_req  (walk_req),
    .walk_vpn  (walk_vpn)
  );

  assign rsp_pa = {lk_ppn, lk_va[PAGE_W-1:0]};
  assign rsp_rd = lk_perm.rd;
  assign rsp_wr = lk_perm.wr;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int VPN_W   = 20,
  parameter int PAGE_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_va,
  input logic               rsp_valid,
  input logic               walk_req,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic               fill_valid,
  input logic               inv_one_valid,
  input logic [VA_W-1:0]    inv_va,
  input logic               inv_all,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] hit_vec
);

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid |=> walk_req && $stable(walk_vpn));

  // R4
  no_rsp_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !walk_req);

  // R8
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_vec == '0);

  // R6
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R10
  inv_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && inv_one_valid && inv_va[VA_W-1:PAGE_W] == lk_va[VA_W-1:PAGE_W]
    |-> !rsp_valid);

endmodule

bind xlat_cache xlat_cache_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .VPN_W(VPN_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_va        (lk_va),
  .rsp_valid    (rsp_valid),
  .walk_req     (walk_req),
  .walk_vpn     (walk_vpn),
  .fill_valid   (fill_valid),
  .inv_one_valid(inv_one_valid),
  .inv_va       (inv_va),
  .inv_all      (inv_all),
  .valid_vec    (valid_vec),
  .hit_vec      (hit_vec)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        lk_valid = 0, rsp_ready = 0, fill_valid = 0, fill_rd = 0, fill_wr = 0;
  logic        inv_one_valid = 0, inv_all = 0;
  logic [31:0] lk_va = 0, inv_va = 0;
  logic [19:0] fill_vpn = 0, fill_ppn = 0;
  logic        lk_ready, rsp_valid, rsp_rd, rsp_wr, walk_req;
  logic [31:0] rsp_pa;
  logic [19:0] walk_vpn;

  // values applied at the next falling edge
  logic        s_lk_valid = 0, s_rsp_ready = 0, s_fill_valid = 0, s_fill_rd = 0, s_fill_wr = 0;
  logic        s_inv_one = 0, s_inv_all = 0;
  logic [31:0] s_lk_va = 0, s_inv_va = 0;
  logic [19:0] s_fill_vpn = 0, s_fill_ppn = 0;

  // model of the cache
  bit          m_vld [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  bit          m_rd [N];
  bit          m_wr [N];
  int          m_ptr = 0;
  bit          m_wait = 0;
  logic [19:0] m_wvpn = 0;

  // observations of the last tick
  bit          last_rv, last_lkr, last_walk, last_rd, last_wr;
  logic [31:0] last_pa;
  logic [19:0] last_wvpn;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_rd(rsp_rd),
    .rsp_wr(rsp_wr), .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .inv_one_valid(inv_one_valid), .inv_va(inv_va), .inv_all(inv_all)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [19:0] lv, iv, fv;
    bit hit, blk, erv, fok, dup;
    int hidx, didx, widx;
    @(negedge clk);
    lk_valid = s_lk_valid;   lk_va = s_lk_va;       rsp_ready = s_rsp_ready;
    fill_valid = s_fill_valid; fill_vpn = s_fill_vpn; fill_ppn = s_fill_ppn;
    fill_rd = s_fill_rd;     fill_wr = s_fill_wr;
    inv_one_valid = s_inv_one; inv_va = s_inv_va;   inv_all = s_inv_all;
    #1;
    lv = lk_va[31:12]; iv = inv_va[31:12]; fv = fill_vpn;
    hit = 0; hidx = 0;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == lv) begin hit = 1; hidx = i; end
    blk = inv_all || (inv_one_valid && iv == lv);
    erv = !m_wait && lk_valid && hit && !blk;
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'(erv));
    chk("R3", "lk_ready", 32'(lk_ready), 32'(erv && rsp_ready));
    chk("R4", "walk_req", 32'(walk_req), 32'(m_wait));
    if (m_wait) chk("R4", "walk_vpn", 32'(walk_vpn), 32'(m_wvpn));
    if (erv) begin
      chk("R2", "rsp_pa", rsp_pa, {m_ppn[hidx], lk_va[11:0]});
      chk("R2", "rsp_rd", 32'(rsp_rd), 32'(m_rd[hidx]));
      chk("R2", "rsp_wr", 32'(rsp_wr), 32'(m_wr[hidx]));
    end
    last_rv = rsp_valid; last_lkr = lk_ready; last_walk = walk_req; last_wvpn = walk_vpn;
    last_pa = rsp_pa; last_rd = rsp_rd; last_wr = rsp_wr;
    // model state update for the coming edge
    fok = fill_valid && !inv_all && !(inv_one_valid && iv == fv);
    dup = 0; didx = 0;
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == fv) begin dup = 1; didx = i; end
    widx = dup ? didx : m_ptr;
    for (int i = 0; i < N; i++) begin
      if (inv_all) m_vld[i] = 0;
      else if (fok && i == widx) begin
        m_vld[i] = 1; m_vpn[i] = fv; m_ppn[i] = fill_ppn; m_rd[i] = fill_rd; m_wr[i] = fill_wr;
      end else if (inv_one_valid && m_vpn[i] == iv) m_vld[i] = 0;
    end
    if (fok && !dup) m_ptr = (m_ptr + 1) % N;
    if (!m_wait) begin
      if (lk_valid && !hit && !blk) begin m_wait = 1; m_wvpn = lv; end
    end else if (fill_valid) m_wait = 0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit rd, input bit wr);
    s_fill_valid = 1; s_fill_vpn = vpn; s_fill_ppn = ppn; s_fill_rd = rd; s_fill_wr = wr;
    tick();
    s_fill_valid = 0;
  endtask

  // one lookup; a miss is released by a fill that an invalidation of the same page cancels
  task automatic probe(input logic [31:0] va, output bit hit, output logic [31:0] pa,
                       output bit rd, output bit wr);
    s_lk_valid = 1; s_lk_va = va; s_rsp_ready = 1;
    tick();
    hit = last_rv; pa = last_pa; rd = last_rd; wr = last_wr;
    s_lk_valid = 0;
    if (!hit) begin
      tick();
      s_fill_valid = 1; s_fill_vpn = va[31:12]; s_fill_ppn = '0;
      s_inv_one = 1; s_inv_va = va;
      tick();
      s_fill_valid = 0; s_inv_one = 0;
    end
  endtask

  function automatic logic [31:0] rand_va();
    return {16'h0ABC, 4'($urandom), 12'($urandom)};
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit h, rd, wr;
    logic [31:0] pa;
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_rd[i] = 0; m_wr[i] = 0; end
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "walk_req in reset", 32'(walk_req), 0);
    chk("R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1", "walk_req after reset", 32'(last_walk), 0);
    probe(32'h1234_5678, h, pa, rd, wr);
    chk("R1", "first lookup hit", 32'(h), 0);

    // R2: basic hit with permissions
    fill(20'h00010, 20'hABCDE, 1, 0);
    probe(32'h0001_0234, h, pa, rd, wr);
    chk("R2", "hit", 32'(h), 1);
    chk("R2", "pa", pa, 32'hABCD_E234);
    chk("R2", "rd", 32'(rd), 1);
    chk("R2", "wr", 32'(wr), 0);

    // R6: refill of the same tag rewrites in place
    fill(20'h00010, 20'h11111, 0, 1);
    for (int k = 0; k < 7; k++) fill(20'h00020 + 20'(k), 20'h20000 + 20'(k), 1, 1);
    probe(32'h0001_0000, h, pa, rd, wr);
    chk("R6", "refilled tag kept", 32'(h), 1);
    chk("R6", "refilled pa", pa, 32'h1111_1000);
    chk("R6", "refilled wr", 32'(wr), 1);

    // R5: ninth distinct tag evicts the first
    fill(20'h00027, 20'h27000, 1, 0);
    probe(32'h0001_0000, h, pa, rd, wr);
    chk("R5", "oldest line evicted", 32'(h), 0);
    probe(32'h0002_0000, h, pa, rd, wr);
    chk("R5", "second line kept", 32'(h), 1);

    // R7: range invalidation stepping 4 KiB
    for (int k = 0; k < 3; k++) begin
      s_inv_one = 1; s_inv_va = 32'h0002_1000 + 32'(k) * 32'h1000;
      tick();
    end
    s_inv_one = 0;
    probe(32'h0002_2000, h, pa, rd, wr);
    chk("R7", "page in range dropped", 32'(h), 0);
    probe(32'h0002_4000, h, pa, rd, wr);
    chk("R7", "page past range kept", 32'(h), 1);

    // R9: fill and invalidation of the same page collide
    s_inv_one = 1; s_inv_va = 32'h0003_0ABC;
    fill(20'h00030, 20'h30303, 1, 1);
    s_inv_one = 0;
    probe(32'h0003_0000, h, pa, rd, wr);
    chk("R9", "colliding fill dropped", 32'(h), 0);
    s_inv_one = 1; s_inv_va = 32'h0003_2000;
    fill(20'h00031, 20'h31313, 1, 1);
    s_inv_one = 0;
    probe(32'h0003_1000, h, pa, rd, wr);
    chk("R9", "fill beside other-page invalidation", 32'(h), 1);

    // R10: lookup meets invalidation of its own page
    s_lk_valid = 1; s_lk_va = 32'h0002_4000; s_rsp_ready = 1;
    s_inv_one = 1; s_inv_va = 32'h0002_4FFF;
    tick();
    chk("R10", "no response", 32'(last_rv), 0);
    s_inv_one = 0; s_lk_valid = 0;
    tick();
    chk("R10", "no walk started", 32'(last_walk), 0);
    probe(32'h0002_4000, h, pa, rd, wr);
    chk("R7", "invalidated page misses", 32'(h), 0);

    // R3: back-pressure holds the response
    fill(20'h00040, 20'h04444, 1, 1);
    s_lk_valid = 1; s_lk_va = 32'h0004_09AC; s_rsp_ready = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3", "held rsp_valid", 32'(last_rv), 1);
      chk("R3", "held lk_ready", 32'(last_lkr), 0);
      chk("R3", "held rsp_pa", last_pa, 32'h0444_49AC);
    end
    s_rsp_ready = 1;
    tick();
    chk("R3", "accept", 32'(last_lkr), 1);
    s_lk_valid = 0;

    // R4: miss, walk held, fill completes it
    s_lk_valid = 1; s_lk_va = 32'h0005_0010;
    tick();
    chk("R4", "miss no response", 32'(last_rv), 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R4", "walk_req held", 32'(last_walk), 1);
      chk("R4", "walk_vpn", 32'(last_wvpn), 32'h00050);
    end
    fill(20'h00050, 20'h55555, 1, 0);
    tick();
    chk("R4", "response after fill", 32'(last_rv), 1);
    chk("R4", "pa after fill", last_pa, 32'h5555_5010);
    s_lk_valid = 0;

    // R8: flush all
    s_inv_all = 1;
    tick();
    s_inv_all = 0;
    probe(32'h0004_0000, h, pa, rd, wr);
    chk("R8", "flushed line a", 32'(h), 0);
    probe(32'h0003_1000, h, pa, rd, wr);
    chk("R8", "flushed line b", 32'(h), 0);

    // constrained random traffic, judged by the model each cycle
    s_lk_valid = 0;
    for (int c = 0; c < 4000; c++) begin
      if (!s_lk_valid && ($urandom % 10) < 6) begin s_lk_valid = 1; s_lk_va = rand_va(); end
      s_rsp_ready = (($urandom % 4) != 0);
      if (m_wait && ($urandom % 3) == 0) begin
        s_fill_valid = 1; s_fill_vpn = m_wvpn; s_fill_ppn = 20'($urandom);
        s_fill_rd = 1'($urandom); s_fill_wr = 1'($urandom);
      end else if (!m_wait && ($urandom % 20) == 0) begin
        s_fill_valid = 1; s_fill_vpn = rand_va() >> 12; s_fill_ppn = 20'($urandom);
        s_fill_rd = 1'($urandom); s_fill_wr = 1'($urandom);
      end
      if (($urandom % 12) == 0) begin s_inv_one = 1; s_inv_va = rand_va(); end
      if (($urandom % 150) == 0) s_inv_all = 1;
      tick();
      if (last_lkr) s_lk_valid = 0;
      s_fill_valid = 0; s_inv_one = 0; s_inv_all = 0;
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule